// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel data words into asynchronous serial frames on a single output line. A frame opens with a low start bit, carries 8 or 9 data bits least significant bit first, may add an even or odd parity bit, and closes with one or two high stop bits. Each bit lasts from one pulse of the external bit-rate tick to the next; the divider that makes the tick sits outside the block.

A holding register stands in front of the shift register. Software may write the next word while the current frame is still on the line, and that word follows the previous frame's last stop bit with no gap. The data-register-empty flag shows that the holding register can take a word. The transmission-complete flag shows that the line has gone quiet with nothing left to send. Both flags, each gated by its own enable, drive one interrupt line. On request the block also sends a whole character time of zeros (a break) or of ones (an idle character), so the far receiver can be resynchronized or woken up.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After a synchronous reset, tx_line is 1, dre is 1 and tc is 1.
- R2: A data frame is a start bit of 0, then the data bits least significant bit first, then the optional parity bit, then stop bits of 1. tx_line changes only in the cycle after a clock edge at which bit_tick was 1, and each bit lasts from one tick to the next.
- R3: With cfg_nine = 0 a frame carries wr_data[7:0]. With cfg_nine = 1 it carries wr_data[8:0].
- R4: With cfg_par_en = 1 a parity bit follows the data. With cfg_par_odd = 0 the number of ones in the data and parity together is even; with cfg_par_odd = 1 it is odd.
- R5: cfg_two_stop = 0 gives one stop bit and cfg_two_stop = 1 gives two. The configuration is taken when a frame is loaded.
- R6: A write (wr_en = 1) clears dre from the next cycle on. dre returns to 1 at the bit_tick edge that moves the word into the shift register. A second write before that edge replaces the held word.
- R7: When a word is waiting as the last stop bit ends, its start bit follows at once, with no idle bit in between.
- R8: tc is 1 only while the shift register is idle and no word, break or idle request is pending. It falls in the cycle after a write or request, and it rises only at a bit_tick edge.
- R9: A pulse on brk_req sends N zero bits, where N = 1 + data bits + parity bit + stop bits under the current configuration.
- R10: A pulse on idle_req sends N one bits (the same N), and tc stays 0 while they are sent.
- R11: When several sources are pending at a load, the break goes first, then the idle character, then the data word.
- R12: irq is 1 exactly when (dre and ie_dre) or (tc and ie_tc).
- R13: If a write and a data load fall at the same clock edge, the shift register takes the word held before the edge, the new word stays held, and dre stays 0.
- R14: tx_line is 1 whenever nothing is being sent, including at bit_tick edges with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Data word; bit 8 is used only in 9-bit mode |
| cfg_nine | input | 1 | 1 = nine data bits, 0 = eight |
| cfg_par_en | input | 1 | 1 = append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| brk_req | input | 1 | Pulse: queue one break character |
| idle_req | input | 1 | Pulse: queue one idle character |
| ie_dre | input | 1 | Interrupt enable for dre |
| ie_tc | input | 1 | Interrupt enable for tc |
| tx_line | output | 1 | Serial output, high when quiet |
| dre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| irq | output | 1 | Combined interrupt |

## Verification
A host write and the transfer of the held word into the shift register can land on the same clock edge, because a write does not wait for a tick. The bench provokes this by raising wr_en and bit_tick together while an older word waits with the shifter idle. It then checks that the start bit appears, that dre stays 0, and that the older word goes out first with the newer one right behind it. A second collision, a break, an idle request and a write all pending together, is judged by the order of the three characters on the line.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int DATA_MAX  = 9;
    localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int NUM_REQ   = 2;   // index 0: break, index 1: idle

    typedef logic [FRAME_MAX-1:0] frame_t;
    typedef logic [LEN_W-1:0]     flen_t;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } tx_cfg_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_BREAK,
        SRC_IDLE,
        SRC_DATA
    } tx_src_e;

    // Number of bit times in one character under a given configuration.
    function automatic flen_t frame_len(tx_cfg_t c);
        int n;
        n = 1 + (c.nine ? 9 : 8) + (c.par_en ? 1 : 0) + (c.two_stop ? 2 : 1);
        return flen_t'(n);
    endfunction

    // Parity bit: even mode yields the XOR of the data bits, odd mode its inverse.
    function automatic logic parity_bit(logic [DATA_MAX-1:0] d, tx_cfg_t c);
        logic acc;
        acc = c.par_odd;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < 8 || c.nine) acc = acc ^ d[i];
        end
        return acc;
    endfunction

    // Frame image, bit 0 goes out first. Unused upper positions are stop ones.
    function automatic frame_t build_frame(logic [DATA_MAX-1:0] d, tx_cfg_t c);
        frame_t f;
        int     ppos;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[1 + i] = d[i];
        if (c.nine) f[9] = d[8];
        ppos = c.nine ? 10 : 9;
        if (c.par_en) f[ppos] = parity_bit(d, c);
        return f;
    endfunction

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    // A write wins over a take at the same edge: the newer word stays held.
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_req_latch.sv
module tx_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic take,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)       pend <= 1'b0;
        else if (req)  pend <= 1'b1;
        else if (take) pend <= 1'b0;
    end
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
    parameter int FW = 13,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  logic          avail,
    input  logic [FW-1:0] load_frame,
    input  logic [LW-1:0] load_len,
    output logic          line,
    output logic          busy,
    output logic          take
);
    logic [FW-1:0] sh;
    logic [LW-1:0] left;
    logic          last;

    assign last = (left == LW'(1));
    // A load happens on a tick when idle, or on the tick that ends the last bit.
    assign take = bit_tick & avail & (~busy | last);
    assign line = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (bit_tick) begin
            if (take) begin
                busy <= 1'b1;
                sh   <= load_frame;
                left <= load_len;
            end else if (busy) begin
                if (last) busy <= 1'b0;
                left <= left - LW'(1);
                sh   <= {1'b1, sh[FW-1:1]};
            end
        end
    end
endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
    import ser_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       wr_en,
    input  logic [8:0] wr_data,
    input  logic       cfg_nine,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       brk_req,
    input  logic       idle_req,
    input  logic       ie_dre,
    input  logic       ie_tc,
    output logic       tx_line,
    output logic       dre,
    output logic       tc,
    output logic       irq
);
    tx_cfg_t              cfg;
    logic                 hold_full;
    logic [DATA_MAX-1:0]  hold_data;
    logic [NUM_REQ-1:0]   req_vec, pend_vec, take_vec;
    logic                 avail, take, busy, take_data;
    tx_src_e              src;
    frame_t               next_frame;
    flen_t                next_len;

    assign cfg = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    tx_hold_reg #(.DW(DATA_MAX)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take_data),
        .full    (hold_full),
        .data    (hold_data)
    );

    assign req_vec = {idle_req, brk_req};

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        tx_req_latch u_req (
            .clk  (clk),
            .rst  (rst),
            .req  (req_vec[g]),
            .take (take_vec[g]),
            .pend (pend_vec[g])
        );
    end

    // Fixed priority: break, then idle character, then data word.
    always_comb begin
        if (pend_vec[0])      src = SRC_BREAK;
        else if (pend_vec[1]) src = SRC_IDLE;
        else if (hold_full)   src = SRC_DATA;
        else                  src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_BREAK: next_frame = '0;
            SRC_DATA:  next_frame = build_frame(hold_data, cfg);
            default:   next_frame = '1;
        endcase
    end

    assign next_len    = frame_len(cfg);
    assign avail       = (src != SRC_NONE);
    assign take_vec[0] = take & (src == SRC_BREAK);
    assign take_vec[1] = take & (src == SRC_IDLE);
    assign take_data   = take & (src == SRC_DATA);

    tx_frame_shifter #(.FW(FRAME_MAX), .LW(LEN_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .avail      (avail),
        .load_frame (next_frame),
        .load_len   (next_len),
        .line       (tx_line),
        .busy       (busy),
        .take       (take)
    );

    assign dre = ~hold_full;
    assign tc  = ~busy & ~avail;
    assign irq = (dre & ie_dre) | (tc & ie_tc);
endmodule

// File: rtl/tx_checker.sv
module tx_checker (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic wr_en,
    input logic ie_dre,
    input logic ie_tc,
    input logic tx_line,
    input logic dre,
    input logic tc,
    input logic irq
);
    assert_quiet_line_high_R14: assert property (@(posedge clk) disable iff (rst)
        tc |-> tx_line);

    assert_write_clears_dre_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !dre);

    assert_dre_sets_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dre) |-> $past(bit_tick));

    assert_tc_needs_empty_R8: assert property (@(posedge clk) disable iff (rst)
        tc |-> dre);

    assert_tc_rises_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tc) |-> $past(bit_tick));

    assert_line_paced_by_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_tick) |-> $stable(tx_line));

    assert_irq_from_flags_R12: assert property (@(posedge clk) disable iff (rst)
        ((dre && ie_dre) || (tc && ie_tc)) |-> irq);

    assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!(dre && ie_dre) && !(tc && ie_tc)) |-> !irq);
endmodule

bind ser_tx_dbuf tx_checker u_tx_checker (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .wr_en    (wr_en),
    .ie_dre   (ie_dre),
    .ie_tc    (ie_tc),
    .tx_line  (tx_line),
    .dre      (dre),
    .tc       (tc),
    .irq      (irq)
);

// File: tb/test_ser_tx_dbuf.sv
module test_ser_tx_dbuf;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0, wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       brk_req = 1'b0, idle_req = 1'b0, ie_dre = 1'b0, ie_tc = 1'b0;
    logic       tx_line, dre, tc, irq;

    int checks = 0;
    int errors = 0;
    logic exp_bits [0:15];
    int   exp_n;

    always #4 clk = ~clk;

    ser_tx_dbuf i_ser_tx_dbuf (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .brk_req(brk_req), .idle_req(idle_req),
        .ie_dre(ie_dre), .ie_tc(ie_tc), .tx_line(tx_line), .dre(dre), .tc(tc), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cfg(logic nine, logic pe, logic po, logic two);
        cfg_nine = nine; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = two;
    endtask

    function automatic int char_len();
        return 1 + (cfg_nine ? 9 : 8) + (cfg_par_en ? 1 : 0) + (cfg_two_stop ? 2 : 1);
    endfunction

    // Expected bits of a data frame, derived from R2..R5.
    task automatic make_data_exp(logic [8:0] d);
        int dw, ones, k;
        dw = cfg_nine ? 9 : 8;
        ones = 0;
        k = 0;
        exp_bits[k++] = 1'b0;
        for (int i = 0; i < dw; i++) begin
            exp_bits[k++] = d[i];
            if (d[i]) ones++;
        end
        if (cfg_par_en) exp_bits[k++] = cfg_par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
        exp_bits[k++] = 1'b1;
        if (cfg_two_stop) exp_bits[k++] = 1'b1;
        exp_n = k;
    endtask

    task automatic make_fill_exp(logic v);
        exp_n = char_len();
        for (int i = 0; i < exp_n; i++) exp_bits[i] = v;
    endtask

    task automatic tick_once();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic write_word(logic [8:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic check_from(int first, string req);
        for (int k = first; k < exp_n; k++) begin
            tick_once();
            chk(req, tx_line, exp_bits[k]);
        end
    endtask

    task automatic expect_quiet(string req);
        tick_once();
        chk({req, " line"}, tx_line, 1);
        chk({req, " tc"}, tc, 1);
        chk({req, " dre"}, dre, 1);
    endtask

    task automatic t_reset();
        chk("R1 line", tx_line, 1);
        chk("R1 dre", dre, 1);
        chk("R1 tc", tc, 1);
    endtask

    task automatic t_frame(logic [8:0] d, logic nine, logic pe, logic po, logic two, string req);
        set_cfg(nine, pe, po, two);
        write_word(d);
        chk("R6 dre after write", dre, 0);
        chk("R8 tc after write", tc, 0);
        make_data_exp(d);
        check_from(0, req);
        expect_quiet(req);
    endtask

    task automatic t_quiet_ticks();
        for (int i = 0; i < 3; i++) begin
            tick_once();
            chk("R14 idle tick", tx_line, 1);
        end
    endtask

    task automatic t_overwrite();
        set_cfg(0, 0, 0, 0);
        write_word(9'h011);
        write_word(9'h0E7);
        make_data_exp(9'h0E7);
        check_from(0, "R6 overwrite");
        expect_quiet("R6 overwrite end");
    endtask

    task automatic t_back_to_back();
        set_cfg(0, 1, 0, 0);
        write_word(9'h03C);
        tick_once();
        chk("R6 dre after load", dre, 1);
        chk("R2 start", tx_line, 0);
        write_word(9'h0C9);
        chk("R6 dre refilled", dre, 0);
        make_data_exp(9'h03C);
        check_from(1, "R2 first frame");
        tick_once();
        chk("R7 no gap", tx_line, 0);
        chk("R7 tc low", tc, 0);
        chk("R7 dre", dre, 1);
        make_data_exp(9'h0C9);
        check_from(1, "R7 second frame");
        expect_quiet("R7 end");
    endtask

    task automatic t_same_cycle();
        set_cfg(0, 0, 0, 1);
        write_word(9'h05A);
        @(negedge clk) begin wr_en = 1'b1; wr_data = 9'h0B4; bit_tick = 1'b1; end
        @(negedge clk) begin wr_en = 1'b0; bit_tick = 1'b0; end
        chk("R13 start", tx_line, 0);
        chk("R13 dre held", dre, 0);
        make_data_exp(9'h05A);
        check_from(1, "R13 older first");
        make_data_exp(9'h0B4);
        check_from(0, "R13 newer next");
        expect_quiet("R13 end");
    endtask

    task automatic t_break();
        set_cfg(0, 1, 0, 1);
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk) brk_req = 1'b0;
        chk("R8 tc on break req", tc, 0);
        make_fill_exp(1'b0);
        chk("R9 length", exp_n, 12);
        check_from(0, "R9 break");
        expect_quiet("R9 end");
    endtask

    task automatic t_idle();
        set_cfg(1, 0, 0, 0);
        @(negedge clk) idle_req = 1'b1;
        @(negedge clk) idle_req = 1'b0;
        make_fill_exp(1'b1);
        for (int k = 0; k < exp_n; k++) begin
            tick_once();
            chk("R10 idle bit", tx_line, 1);
            chk("R10 tc low", tc, 0);
        end
        expect_quiet("R10 end");
    endtask

    task automatic t_priority();
        set_cfg(0, 0, 0, 0);
        @(negedge clk) begin brk_req = 1'b1; idle_req = 1'b1; wr_en = 1'b1; wr_data = 9'h0F0; end
        @(negedge clk) begin brk_req = 1'b0; idle_req = 1'b0; wr_en = 1'b0; end
        make_fill_exp(1'b0);
        check_from(0, "R11 break first");
        make_fill_exp(1'b1);
        check_from(0, "R11 idle second");
        chk("R11 data waiting", dre, 0);
        make_data_exp(9'h0F0);
        check_from(0, "R11 data last");
        expect_quiet("R11 end");
    endtask

    task automatic t_irq();
        @(negedge clk) begin ie_dre = 1'b0; ie_tc = 1'b0; end
        @(negedge clk) chk("R12 none", irq, 0);
        ie_tc = 1'b1;
        @(negedge clk) chk("R12 tc", irq, 1);
        ie_dre = 1'b1;
        set_cfg(0, 0, 0, 0);
        write_word(9'h001);
        chk("R12 both flags low", irq, 0);
        tick_once();
        chk("R12 dre back", irq, 1);
        ie_dre = 1'b0;
        @(negedge clk) chk("R12 dre masked", irq, 0);
        make_data_exp(9'h001);
        check_from(1, "R12 frame");
        tick_once();
        chk("R12 tc at end", irq, 1);
        ie_tc = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_quiet_ticks();
        t_frame(9'h0A5, 0, 0, 0, 0, "R2 8N1");
        t_frame(9'h1C3, 1, 1, 0, 1, "R3 R4 R5 9E2");
        t_frame(9'h0B1, 0, 1, 1, 0, "R4 odd");
        t_frame(9'h100, 1, 1, 1, 0, "R3 ninth bit odd");
        t_frame(9'h1FF, 0, 0, 0, 1, "R3 bit8 dropped R5");
        t_overwrite();
        t_back_to_back();
        t_same_cycle();
        t_break();
        t_idle();
        t_priority();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule